// File: doc/BRIEF.md
# Timer input capture conditioning

This block turns one external timer input into a clean capture event for a timer channel. The raw pin is brought into the clock domain by a two-stage synchronizer. A digital filter then moves its output to a new level only after a configurable number of consecutive samples agree at that level. The filter takes its samples on a sampling strobe, `samp_en`, which stands in for a dedicated sampling clock. Rising and falling transitions of the filtered level are detected. A both-edge pulse from this channel's own filtered input goes straight out to a slave controller, so that path never passes through the capture selection.

The capture path picks its event source from three places: this channel's filtered edges, the neighbouring channel's edge pulses, or an internal trigger pulse. A polarity setting chooses whether rising edges, falling edges or both count. A prescaler then lets through only every 1st, 2nd, 4th or 8th event. Each event it lets through appears as a one-cycle `cap_pulse`. The counter, the capture registers and the bus access are outside this block.

Top module: `capin_cond`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cap_pulse`, `slave_edge` and `flt_level` are all 0.
- R2: The filter waits for N consecutive samples that differ from its output, where N = `flt_cfg` + 1. A setting of 0 means no filtering: every clock is a sample. With samples on every clock, a pin change driven just after clock edge c makes `flt_level` change at edge c+2+N. `slave_edge` is then high for the cycle after edge c+2+N, and an accepted `cap_pulse` is high for the cycle after edge c+3+N.
- R3: When `flt_cfg` is non-zero, the filter samples only in cycles where `samp_en` is 1, and `flt_level` holds while `samp_en` is 0. A pulse seen by fewer than N consecutive samples is rejected: there is no `slave_edge` and no capture.
- R4: `edge_pol` selects the active edge. 2'b00 or 2'b10 means rising only, 2'b01 means falling only, and 2'b11 means both edges.
- R5: `src_sel` selects the event source. 2'b01 is the own filtered input, 2'b10 is the neighbour edges and 2'b11 is the internal trigger. 2'b00 means the channel is not capturing and produces no `cap_pulse`.
- R6: The neighbour's `nbr_rise` and `nbr_fall` pulses go through the same polarity choice as the own input. The trigger ignores polarity. A selected neighbour or trigger pulse present in the cycle after edge c gives `cap_pulse` in the cycle after edge c+1, and back-to-back pulses give back-to-back captures when the division is 1.
- R7: `psc_sel` = p passes every 2^p-th selected event, starting with the 2^p-th event after the count was last cleared.
- R8: The prescaler count clears in any cycle where `psc_sel` differs from its value in the previous cycle. An event arriving in that same cycle is dropped and not counted.
- R9: While `chan_en` is 0, no `cap_pulse` is produced and the prescaler count is cleared.
- R10: `slave_edge` pulses on every transition of the own filtered input, whatever the values of `src_sel`, `edge_pol` and `chan_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 1 | Unsynchronized external input |
| samp_en | input | 1 | Filter sampling strobe |
| flt_cfg | input | 4 | Filter setting, N = value + 1 |
| edge_pol | input | 2 | Active edge selection |
| src_sel | input | 2 | Capture source selection |
| psc_sel | input | 2 | Prescaler setting, divide by 2^value |
| chan_en | input | 1 | Channel capture enable |
| nbr_rise | input | 1 | Neighbour filtered rising-edge pulse |
| nbr_fall | input | 1 | Neighbour filtered falling-edge pulse |
| trig_in | input | 1 | Internal trigger pulse |
| cap_pulse | output | 1 | One-cycle prescaled capture event |
| slave_edge | output | 1 | Both-edge pulse of own filtered input |
| flt_level | output | 1 | Filtered input level |

## Verification
A change of the prescaler setting and a selected event can fall in the same cycle. The clear then competes with the count. The bench provokes this by driving a trigger pulse on the same edge that it moves `psc_sel` to a new value. It judges the outcome by where the next capture lands: it must fall on the fourth later trigger at divide-by-4, not the third. Disabling the channel next to a pending partial count is checked the same way, by counting triggers to the next capture.

// File: rtl/capin_pkg.sv
package capin_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_OWN  = 2'b01,
    SRC_NBR  = 2'b10,
    SRC_TRG  = 2'b11
  } capin_src_e;

  // Polarity decode: 2'b11 takes both edges, 2'b01 falling only, else rising.
  function automatic logic edge_hit(input logic [1:0] pol, input logic rise, input logic fall);
    logic hit;
    if (pol == 2'b11)      hit = rise | fall;
    else if (pol == 2'b01) hit = fall;
    else                   hit = rise;
    return hit;
  endfunction

endpackage

// File: rtl/capin_sync.sv
module capin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/capin_filter.sv
module capin_filter #(
  parameter int CFG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             samp_en,
  input  logic [CFG_W-1:0] cfg,
  input  logic             d,
  output logic             q
);
  logic [CFG_W-1:0] run;
  logic             take;

  // Reaching the last required sample: run counts disagreeing samples seen so far.
  function automatic logic run_done(input logic [CFG_W-1:0] r, input logic [CFG_W-1:0] c);
    return r >= c;
  endfunction

  // A zero setting bypasses the strobe so every clock is a sample.
  assign take = (cfg == '0) | samp_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= 1'b0;
      run <= '0;
    end else if (take) begin
      if (d == q) begin
        run <= '0;
      end else if (run_done(run, cfg)) begin
        q   <= d;
        run <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
  end
endmodule

// File: rtl/capin_edge_sel.sv
module capin_edge_sel
  import capin_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flt,
  input  logic       nbr_rise,
  input  logic       nbr_fall,
  input  logic       trg,
  input  logic [1:0] pol,
  input  logic [1:0] src,
  output logic       own_rise,
  output logic       own_fall,
  output logic       both_edge,
  output logic       evt
);
  logic flt_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flt_d <= 1'b0;
    else        flt_d <= flt;

  assign own_rise  = flt & ~flt_d;
  assign own_fall  = ~flt & flt_d;
  assign both_edge = own_rise | own_fall;

  always_comb begin
    unique case (capin_src_e'(src))
      SRC_OWN:  evt = edge_hit(pol, own_rise, own_fall);
      SRC_NBR:  evt = edge_hit(pol, nbr_rise, nbr_fall);
      SRC_TRG:  evt = trg;
      default:  evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/capin_presc.sv
module capin_presc #(
  parameter int PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PSC_W-1:0] psc,
  input  logic             evt,
  output logic             clr,
  output logic             pulse
);
  localparam int MAX_LOG = (1 << PSC_W) - 1;
  localparam int CNT_W   = (MAX_LOG > 0) ? MAX_LOG : 1;

  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] cnt;

  // Index of the event that completes one division period.
  function automatic logic [CNT_W-1:0] last_idx(input logic [PSC_W-1:0] p);
    int unsigned v;
    v = (32'd1 << p) - 32'd1;
    return v[CNT_W-1:0];
  endfunction

  assign clr = !en || (psc != psc_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q <= '0;
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      psc_q <= psc;
      pulse <= 1'b0;
      if (clr) begin
        cnt <= '0;
      end else if (evt) begin
        if (cnt == last_idx(psc)) begin
          cnt   <= '0;
          pulse <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/capin_cond.sv
module capin_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int CFG_W       = 4,
  parameter int PSC_W       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_raw,
  input  logic             samp_en,
  input  logic [CFG_W-1:0] flt_cfg,
  input  logic [1:0]       edge_pol,
  input  logic [1:0]       src_sel,
  input  logic [PSC_W-1:0] psc_sel,
  input  logic             chan_en,
  input  logic             nbr_rise,
  input  logic             nbr_fall,
  input  logic             trig_in,
  output logic             cap_pulse,
  output logic             slave_edge,
  output logic             flt_level
);
  logic sync_q;
  logic own_rise;
  logic own_fall;
  logic sel_evt;
  logic psc_clr;

  capin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(sync_q)
  );

  capin_filter #(.CFG_W(CFG_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .cfg(flt_cfg),
    .d(sync_q), .q(flt_level)
  );

  capin_edge_sel u_edge (
    .clk(clk), .rst_n(rst_n), .flt(flt_level),
    .nbr_rise(nbr_rise), .nbr_fall(nbr_fall), .trg(trig_in),
    .pol(edge_pol), .src(src_sel),
    .own_rise(own_rise), .own_fall(own_fall),
    .both_edge(slave_edge), .evt(sel_evt)
  );

  capin_presc #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .en(chan_en), .psc(psc_sel),
    .evt(sel_evt), .clr(psc_clr), .pulse(cap_pulse)
  );
endmodule

// File: rtl/capin_chk.sv
module capin_chk #(
  parameter int CFG_W = 4,
  parameter int PSC_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             samp_en,
  input logic [CFG_W-1:0] flt_cfg,
  input logic [1:0]       src_sel,
  input logic [PSC_W-1:0] psc_sel,
  input logic             chan_en,
  input logic             sync_q,
  input logic             flt_level,
  input logic             cap_pulse
);
  // R9
  cap_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |-> $past(chan_en));

  // R5
  cap_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |-> ($past(src_sel) != 2'b00));

  // R2
  flt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_level != $past(flt_level)) |-> (flt_level == $past(sync_q)));

  // R3
  flt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_cfg != '0 && !samp_en) |=> $stable(flt_level));

  // R8
  psc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |-> ($past(psc_sel) == $past(psc_sel, 2)));
endmodule

bind capin_cond capin_chk #(.CFG_W(CFG_W), .PSC_W(PSC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .flt_cfg(flt_cfg),
  .src_sel(src_sel), .psc_sel(psc_sel), .chan_en(chan_en),
  .sync_q(sync_q), .flt_level(flt_level), .cap_pulse(cap_pulse)
);

// File: tb/sim_capin_cond.sv
module sim_capin_cond;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_raw = 1'b0;
  logic       samp_en = 1'b1;
  logic [3:0] flt_cfg = 4'd0;
  logic [1:0] edge_pol = 2'b00;
  logic [1:0] src_sel = 2'b00;
  logic [1:0] psc_sel = 2'b00;
  logic       chan_en = 1'b0;
  logic       nbr_rise = 1'b0;
  logic       nbr_fall = 1'b0;
  logic       trig_in = 1'b0;
  logic       cap_pulse;
  logic       slave_edge;
  logic       flt_level;

  capin_cond u0 (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .samp_en(samp_en),
    .flt_cfg(flt_cfg), .edge_pol(edge_pol), .src_sel(src_sel),
    .psc_sel(psc_sel), .chan_en(chan_en), .nbr_rise(nbr_rise),
    .nbr_fall(nbr_fall), .trig_in(trig_in), .cap_pulse(cap_pulse),
    .slave_edge(slave_edge), .flt_level(flt_level)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int at; string tag; } exp_t;
  exp_t capq[$];
  exp_t bothq[$];

  int    checks = 0;
  int    fails = 0;
  string cur_tag = "R1";
  bit    both_free = 1'b0;
  int    both_seen = 0;
  int    samp_mode = 1;    // 0 held low, 1 every cycle, 2 every fourth cycle
  int    ev_n = 0;
  int    div = 1;
  bit    en_m = 1'b0;
  bit    pin_m = 1'b0;
  bit    done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", tag, what, act, exp, cyc);
    end
  endtask

  task automatic push_cap(input int at, input string tag);
    exp_t e;
    int i;
    e.at = at; e.tag = tag;
    i = 0;
    while (i < capq.size() && capq[i].at <= at) i++;
    capq.insert(i, e);
  endtask

  task automatic push_both(input int at, input string tag);
    exp_t e;
    int i;
    e.at = at; e.tag = tag;
    i = 0;
    while (i < bothq.size() && bothq[i].at <= at) i++;
    bothq.insert(i, e);
  endtask

  function automatic bit pol_takes(input logic [1:0] pol, input bit rising);
    case (pol)
      2'b11:   return 1'b1;
      2'b01:   return !rising;
      default: return rising;
    endcase
  endfunction

  task automatic count_evt(input int at, input string tag);
    if (!en_m) return;
    ev_n++;
    if (ev_n >= div) begin
      ev_n = 0;
      push_cap(at, tag);
    end
  endtask

  // Sampling strobe driver
  initial forever begin
    @(negedge clk);
    case (samp_mode)
      0:       samp_en = 1'b0;
      2:       samp_en = (cyc % 4 == 0);
      default: samp_en = 1'b1;
    endcase
  end

  // Monitor: compares outputs with the expected queues
  initial forever begin
    @(negedge clk);
    if (rst_n && !done) begin
      if (capq.size() > 0 && capq[0].at == cyc) begin
        check(cap_pulse == 1'b1, capq[0].tag, "cap_pulse", cap_pulse, 1);
        void'(capq.pop_front());
      end else if (cap_pulse) begin
        check(1'b0, cur_tag, "unexpected cap_pulse", 1, 0);
      end
      if (both_free) begin
        if (slave_edge) both_seen++;
      end else if (bothq.size() > 0 && bothq[0].at == cyc) begin
        check(slave_edge == 1'b1, bothq[0].tag, "slave_edge", slave_edge, 1);
        void'(bothq.pop_front());
      end else if (slave_edge) begin
        check(1'b0, cur_tag, "unexpected slave_edge", 1, 0);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pin(input bit v, input string tag);
    int c;
    int n;
    @(negedge clk);
    c = cyc;
    n = int'(flt_cfg) + 1;
    pin_raw = v;
    if (v != pin_m) begin
      push_both(c + 2 + n, "R10");
      if (src_sel == 2'b01 && pol_takes(edge_pol, v)) count_evt(c + 3 + n, tag);
    end
    pin_m = v;
    idle(n + 8);
  endtask

  task automatic nbr_pulse(input bit rising, input string tag);
    @(negedge clk);
    nbr_rise = rising;
    nbr_fall = !rising;
    if (src_sel == 2'b10 && pol_takes(edge_pol, rising)) count_evt(cyc + 1, tag);
    @(negedge clk);
    nbr_rise = 1'b0;
    nbr_fall = 1'b0;
    idle(3);
  endtask

  task automatic trg_burst(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      trig_in = 1'b1;
      if (src_sel == 2'b11) count_evt(cyc + 1, tag);
    end
    @(negedge clk);
    trig_in = 1'b0;
    idle(3);
  endtask

  task automatic set_psc(input logic [1:0] v);
    @(negedge clk);
    psc_sel = v;
    ev_n = 0;
    div = 1 << v;
  endtask

  task automatic psc_with_trg(input logic [1:0] v);
    @(negedge clk);
    psc_sel = v;
    trig_in = 1'b1;
    ev_n = 0;
    div = 1 << v;
    @(negedge clk);
    trig_in = 1'b0;
    idle(3);
  endtask

  task automatic set_en(input bit v);
    @(negedge clk);
    chan_en = v;
    en_m = v;
    if (!v) ev_n = 0;
  endtask

  task automatic finish_up;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog run did not complete");
    finish_up();
  end

  initial begin
    // R1 reset state
    idle(5);
    check(cap_pulse == 1'b0, "R1", "cap_pulse in reset", cap_pulse, 0);
    check(slave_edge == 1'b0, "R1", "slave_edge in reset", slave_edge, 0);
    check(flt_level == 1'b0, "R1", "flt_level in reset", flt_level, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cap_pulse == 1'b0 && flt_level == 1'b0, "R1", "outputs after reset", cap_pulse, 0);

    // R2 latency, unfiltered and filtered
    cur_tag = "R2";
    src_sel = 2'b01; edge_pol = 2'b00; en_m = 1'b1; chan_en = 1'b1;
    set_pin(1'b1, "R2");
    check(flt_level == 1'b1, "R2", "flt_level after rise", flt_level, 1);
    set_pin(1'b0, "R2");
    flt_cfg = 4'd5;
    set_pin(1'b1, "R2");
    set_pin(1'b0, "R2");
    check(flt_level == 1'b0, "R2", "flt_level after fall", flt_level, 0);

    // R3 short pulse rejected with every-cycle sampling
    cur_tag = "R3";
    flt_cfg = 4'd2;
    @(negedge clk); pin_raw = 1'b1;
    @(negedge clk); @(negedge clk); pin_raw = 1'b0;
    idle(10);
    check(flt_level == 1'b0, "R3", "flt_level after short pulse", flt_level, 0);

    // R3 strobed sampling
    src_sel = 2'b00;
    both_free = 1'b1; both_seen = 0;
    flt_cfg = 4'd3; samp_mode = 2;
    idle(2);
    @(negedge clk); pin_raw = 1'b1;
    idle(6);
    pin_raw = 1'b0;
    idle(40);
    check(flt_level == 1'b0 && both_seen == 0, "R3", "strobed glitch edges", both_seen, 0);
    pin_raw = 1'b1;
    idle(60);
    check(flt_level == 1'b1, "R3", "strobed accept level", flt_level, 1);
    check(both_seen == 1, "R3", "strobed accept edges", both_seen, 1);
    samp_mode = 0;
    idle(2);
    pin_raw = 1'b0;
    idle(40);
    check(flt_level == 1'b1, "R3", "level held without strobe", flt_level, 1);
    samp_mode = 1;
    idle(20);
    check(flt_level == 1'b0 && both_seen == 2, "R3", "strobe restored edges", both_seen, 2);
    pin_m = 1'b0;
    both_free = 1'b0;
    idle(4);

    // R4 polarity
    cur_tag = "R4";
    flt_cfg = 4'd0; src_sel = 2'b01;
    edge_pol = 2'b01;
    set_pin(1'b1, "R4"); set_pin(1'b0, "R4");
    edge_pol = 2'b11;
    set_pin(1'b1, "R4"); set_pin(1'b0, "R4");
    edge_pol = 2'b10;
    set_pin(1'b1, "R4"); set_pin(1'b0, "R4");

    // R5 source none, and own pin ignored under other sources
    cur_tag = "R5";
    src_sel = 2'b00; edge_pol = 2'b11;
    trg_burst(2, "R5"); nbr_pulse(1'b1, "R5"); set_pin(1'b1, "R5"); set_pin(1'b0, "R5");
    src_sel = 2'b11;
    trg_burst(1, "R5"); set_pin(1'b1, "R5"); nbr_pulse(1'b0, "R5"); set_pin(1'b0, "R5");

    // R6 neighbour with polarity and back-to-back triggers
    cur_tag = "R6";
    trg_burst(3, "R6");
    src_sel = 2'b10; edge_pol = 2'b00;
    nbr_pulse(1'b1, "R6"); nbr_pulse(1'b0, "R6");
    edge_pol = 2'b01;
    nbr_pulse(1'b1, "R6"); nbr_pulse(1'b0, "R6");
    edge_pol = 2'b11;
    nbr_pulse(1'b1, "R6"); nbr_pulse(1'b0, "R6"); trg_burst(1, "R6");

    // R7 prescaler divisions
    cur_tag = "R7";
    src_sel = 2'b11;
    set_psc(2'd1); trg_burst(5, "R7");
    set_psc(2'd2); idle(2); trg_burst(8, "R7");
    set_psc(2'd3); idle(2); trg_burst(16, "R7");

    // R8 clear on change, simultaneous event dropped
    cur_tag = "R8";
    set_psc(2'd1); idle(2);
    trg_burst(1, "R8");
    set_psc(2'd2); idle(2);
    trg_burst(4, "R8");
    trg_burst(1, "R8");
    psc_with_trg(2'd2 ^ 2'd0 == 2'd2 ? 2'd2 : 2'd2);
    psc_with_trg(2'd1);
    psc_with_trg(2'd2);
    trg_burst(3, "R8");
    trg_burst(1, "R8");

    // R9 disable clears count and blocks capture
    cur_tag = "R9";
    set_psc(2'd1); idle(2);
    trg_burst(1, "R9");
    set_en(1'b0);
    trg_burst(2, "R9");
    set_en(1'b1);
    trg_burst(1, "R9");
    trg_burst(1, "R9");
    set_psc(2'd0); idle(2);
    set_en(1'b0);
    trg_burst(2, "R9");

    // R10 slave edge with capture disabled
    cur_tag = "R10";
    src_sel = 2'b01;
    set_pin(1'b1, "R10"); set_pin(1'b0, "R10");
    set_en(1'b1);
    idle(10);

    check(capq.size() == 0, "R7", "pending captures", capq.size(), 0);
    check(bothq.size() == 0, "R10", "pending slave edges", bothq.size(), 0);
    finish_up();
  end
endmodule